// File: doc/BRIEF.md
# Banked Group-1 Binary Point Register Controller

This block owns the 3-bit binary point for the second interrupt group inside a CPU interrupt interface. The binary point sets where an 8-bit priority splits into a preemption part and a subpriority part. When a monitor level is built in, the block keeps a secure copy and a non-secure copy of the setting. The block also drives both copies out continuously, so that the preemption logic next to it can use them.

Register accesses come in through a one-request-per-cycle port that carries read/write, write data and the requester's privilege level. For each access the block walks a fixed chain of checks over the level, the security state and the routing, trap and enable controls. The chain ends in one of five outcomes: complete, undefined, trap to the hypervisor, trap to the monitor, or redirect to the virtual copy. The virtual copy is held elsewhere, so this block only signals the redirect.

On a completed write the block applies two rules. A written zero becomes the reset value, and when no monitor level is present a value below the reset value is raised to it. When the common-binary-point mode is on, completed non-secure accesses at levels 1 and 2 read the group-0 binary point plus one, saturating at 7, and their writes are dropped.

Top module: `grp1_bp_ctrl`

## Requirements
- R1: Every request produces a response one clock later: `rsp_valid_o` is high exactly in the cycle after `req_valid_i`. Read data bits above bit 2 are always zero. Write responses and non-complete responses return zero data.
- R2: A request at level 0 (`req_level_i`=0) gives outcome undefined (code 1).
- R3: At level 1 the checks are taken in this order, and the first match wins: undefined-priority with effective IRQ routing → undefined (1); hypervisor enabled with T12 → hypervisor trap (2); kernel enable low → undefined (1); hypervisor enabled with trap-all → hypervisor trap (2); hypervisor enabled with IMO → virtual redirect (4); effective IRQ routing → monitor trap (3), or undefined (1) when `sdd_undef_i` is high; otherwise complete (0) on the non-secure copy, or on the single copy when no monitor is present.
- R4: At level 2: undefined-priority with effective IRQ routing → undefined (1); hypervisor enable low → undefined (1); effective IRQ routing → monitor trap (3), or undefined (1) when `sdd_undef_i` is high; otherwise complete (0). Effective IRQ routing is `route_irq_i` when a monitor is present, and 0 otherwise.
- R5: At level 3 with a monitor present and the monitor enable high, the access completes. It uses the secure copy when `ns_i`=0 and the non-secure copy when `ns_i`=1. Without a monitor, or with the monitor enable low, the outcome is undefined (1).
- R6: With `cbpr_i`=1, a completed level-1 or level-2 read returns min(`bpr0_i`+1, 7), and a completed level-1 or level-2 write changes no state.
- R7: A completed write whose low three bits are zero stores the reset value, which is MIN_BPR0+1 (3 by default).
- R8: Without a monitor, a completed write below the reset value stores the reset value. With a monitor, nonzero values are stored as written.
- R9: `rsp_ec_o` is 0x03 on a hypervisor trap and 0 otherwise.
- R10: Stored state changes only on a completed write. Reads and all other outcomes leave both copies unchanged.
- R11: After reset both copies hold the reset value and no response is valid. Without a monitor, `bp_s_o` stays at the reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_level_i | input | 2 | Privilege level of the requester, 0..3 |
| req_wdata_i | input | DATA_W | Write data |
| el2_en_i | input | 1 | Hypervisor level enabled |
| undef_prio_i | input | 1 | Undefined-priority condition active |
| route_irq_i | input | 1 | IRQ routed to monitor |
| imo_i | input | 1 | Hypervisor virtual-IRQ routing |
| t12_i | input | 1 | Hypervisor trap on this register group |
| tall1_i | input | 1 | Hypervisor trap-all for group 1 |
| sre_kern_i | input | 1 | Level-1 system-register enable |
| sre_hyp_i | input | 1 | Level-2 system-register enable |
| sre_mon_i | input | 1 | Level-3 system-register enable |
| ns_i | input | 1 | Monitor-level bank select, 1 = non-secure |
| cbpr_i | input | 1 | Common binary point for non-secure |
| sdd_undef_i | input | 1 | Monitor traps become undefined |
| bpr0_i | input | BP_W | Group-0 binary point |
| rsp_valid_o | output | 1 | Response valid |
| rsp_outcome_o | output | 3 | 0 complete, 1 undefined, 2 hyp trap, 3 monitor trap, 4 virtual |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_ec_o | output | 6 | Exception class for hypervisor traps |
| bp_s_o | output | BP_W | Secure copy |
| bp_ns_o | output | BP_W | Non-secure (or only) copy |

## Verification
All response fields appear one clock after the request edge, and the stored copies change at that same edge. The bench drives inputs on the falling edge and samples at the next falling edge, so each result is read once a single register stage has settled. The bench checks the response and the post-write state together in that cycle, before the next request is applied. A sweep covers every level, direction and control combination on two instances, one with a monitor and one without, against an arithmetic model of the outcome chain and the write rules.

// File: rtl/grp1_bp_pkg.sv
package grp1_bp_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [2:0] {
    OUT_DONE     = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP_HYP = 3'd2,
    OUT_TRAP_MON = 3'd3,
    OUT_VIRT     = 3'd4
  } outcome_e;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_MON  = 2'd3
  } level_e;

  typedef struct packed {
    logic el2_en;
    logic undef_prio;
    logic route_irq;
    logic imo;
    logic t12;
    logic tall1;
    logic sre_kern;
    logic sre_hyp;
    logic sre_mon;
    logic ns;
    logic cbpr;
    logic sdd_undef;
  } ctrl_t;

  localparam int         EC_W        = 6;
  localparam logic [5:0] EC_HYP_TRAP = 6'h03;
endpackage

// File: rtl/grp1_bp_decide.sv
module grp1_bp_decide
  import grp1_bp_pkg::*;
#(
  parameter bit HAS_MONITOR = 1'b1
) (
  input  logic [1:0] level_i,
  input  ctrl_t      ctrl_i,
  output outcome_e   outcome_o,
  output logic       sel_s_o,
  output logic       alias_o
);
  timeunit 1ns; timeprecision 1ps;

  logic     irq_eff;
  outcome_e mon_trap;

  assign irq_eff  = HAS_MONITOR && ctrl_i.route_irq;
  assign mon_trap = ctrl_i.sdd_undef ? OUT_UNDEF : OUT_TRAP_MON;

  always_comb begin
    outcome_o = OUT_UNDEF;
    sel_s_o   = 1'b0;
    alias_o   = 1'b0;
    unique case (level_e'(level_i))
      LVL_KERN: begin
        if (ctrl_i.undef_prio && irq_eff)         outcome_o = OUT_UNDEF;
        else if (ctrl_i.el2_en && ctrl_i.t12)     outcome_o = OUT_TRAP_HYP;
        else if (!ctrl_i.sre_kern)                outcome_o = OUT_UNDEF;
        else if (ctrl_i.el2_en && ctrl_i.tall1)   outcome_o = OUT_TRAP_HYP;
        else if (ctrl_i.el2_en && ctrl_i.imo)     outcome_o = OUT_VIRT;
        else if (irq_eff)                         outcome_o = mon_trap;
        else begin
          outcome_o = OUT_DONE;
          alias_o   = ctrl_i.cbpr;
        end
      end
      LVL_HYP: begin
        if (ctrl_i.undef_prio && irq_eff) outcome_o = OUT_UNDEF;
        else if (!ctrl_i.sre_hyp)         outcome_o = OUT_UNDEF;
        else if (irq_eff)                 outcome_o = mon_trap;
        else begin
          outcome_o = OUT_DONE;
          alias_o   = ctrl_i.cbpr;
        end
      end
      LVL_MON: begin
        if (!HAS_MONITOR || !ctrl_i.sre_mon) outcome_o = OUT_UNDEF;
        else begin
          outcome_o = OUT_DONE;
          sel_s_o   = !ctrl_i.ns;
        end
      end
      default: outcome_o = OUT_UNDEF;
    endcase
  end
endmodule

// File: rtl/grp1_bp_wrmap.sv
module grp1_bp_wrmap #(
  parameter int              BP_W      = 3,
  parameter logic [BP_W-1:0] RST_VAL   = 3'd3,
  parameter bit              CLAMP_LOW = 1'b0
) (
  input  logic [BP_W-1:0] wr_i,
  output logic [BP_W-1:0] val_o
);
  timeunit 1ns; timeprecision 1ps;

  // zero always maps to reset value; optional floor at reset value
  if (CLAMP_LOW) begin : g_clamp
    assign val_o = (wr_i < RST_VAL) ? RST_VAL : wr_i;
  end else begin : g_pass
    assign val_o = (wr_i == '0) ? RST_VAL : wr_i;
  end
endmodule

// File: rtl/grp1_bp_alias.sv
module grp1_bp_alias #(
  parameter int BP_W = 3
) (
  input  logic [BP_W-1:0] bpr0_i,
  output logic [BP_W-1:0] sat_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [BP_W:0] sum;

  // one extra bit so the all-ones input saturates instead of wrapping
  assign sum   = {1'b0, bpr0_i} + {{BP_W{1'b0}}, 1'b1};
  assign sat_o = sum[BP_W] ? {BP_W{1'b1}} : sum[BP_W-1:0];
endmodule

// File: rtl/grp1_bp_ctrl.sv
module grp1_bp_ctrl
  import grp1_bp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BP_W        = 3,
  parameter int MIN_BPR0    = 2,
  parameter bit HAS_MONITOR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_level_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              el2_en_i,
  input  logic              undef_prio_i,
  input  logic              route_irq_i,
  input  logic              imo_i,
  input  logic              t12_i,
  input  logic              tall1_i,
  input  logic              sre_kern_i,
  input  logic              sre_hyp_i,
  input  logic              sre_mon_i,
  input  logic              ns_i,
  input  logic              cbpr_i,
  input  logic              sdd_undef_i,
  input  logic [BP_W-1:0]   bpr0_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_outcome_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [EC_W-1:0]   rsp_ec_o,
  output logic [BP_W-1:0]   bp_s_o,
  output logic [BP_W-1:0]   bp_ns_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [BP_W-1:0] RST_VAL = BP_W'(MIN_BPR0 + 1);
  localparam int              PAD_W   = DATA_W - BP_W;

  ctrl_t           ctrl;
  outcome_e        outcome;
  logic            sel_s;
  logic            alias_en;
  logic [BP_W-1:0] alias_val;
  logic [BP_W-1:0] wr_s_val;
  logic [BP_W-1:0] wr_ns_val;
  logic [BP_W-1:0] bank_val;
  logic [BP_W-1:0] rd_val;
  logic            done_wr;
  logic            done_rd;
  logic            unused_wdata_hi;

  logic [BP_W-1:0]   bp_ns_q;
  logic [BP_W-1:0]   bp_s_q;
  logic              rsp_valid_q;
  outcome_e          rsp_outcome_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic [EC_W-1:0]   rsp_ec_q;

  assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:BP_W];

  assign ctrl = '{el2_en:     el2_en_i,
                  undef_prio: undef_prio_i,
                  route_irq:  route_irq_i,
                  imo:        imo_i,
                  t12:        t12_i,
                  tall1:      tall1_i,
                  sre_kern:   sre_kern_i,
                  sre_hyp:    sre_hyp_i,
                  sre_mon:    sre_mon_i,
                  ns:         ns_i,
                  cbpr:       cbpr_i,
                  sdd_undef:  sdd_undef_i};

  grp1_bp_decide #(.HAS_MONITOR(HAS_MONITOR)) i_decide (
    .level_i  (req_level_i),
    .ctrl_i   (ctrl),
    .outcome_o(outcome),
    .sel_s_o  (sel_s),
    .alias_o  (alias_en)
  );

  grp1_bp_alias #(.BP_W(BP_W)) i_alias (
    .bpr0_i(bpr0_i),
    .sat_o (alias_val)
  );

  // secure bank only reachable at monitor level, never clamped
  grp1_bp_wrmap #(.BP_W(BP_W), .RST_VAL(RST_VAL), .CLAMP_LOW(1'b0)) i_wrmap_s (
    .wr_i (req_wdata_i[BP_W-1:0]),
    .val_o(wr_s_val)
  );

  grp1_bp_wrmap #(.BP_W(BP_W), .RST_VAL(RST_VAL), .CLAMP_LOW(!HAS_MONITOR)) i_wrmap_ns (
    .wr_i (req_wdata_i[BP_W-1:0]),
    .val_o(wr_ns_val)
  );

  assign done_wr  = req_valid_i && req_write_i && (outcome == OUT_DONE) && !alias_en;
  assign done_rd  = req_valid_i && !req_write_i && (outcome == OUT_DONE);
  assign bank_val = sel_s ? bp_s_q : bp_ns_q;
  assign rd_val   = alias_en ? alias_val : bank_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_ns_q <= RST_VAL;
    end else if (done_wr && !sel_s) begin
      bp_ns_q <= wr_ns_val;
    end
  end

  if (HAS_MONITOR) begin : g_sbank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bp_s_q <= RST_VAL;
      end else if (done_wr && sel_s) begin
        bp_s_q <= wr_s_val;
      end
    end
  end else begin : g_no_sbank
    logic unused_s;
    assign unused_s = ^wr_s_val;
    assign bp_s_q   = RST_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q   <= 1'b0;
      rsp_outcome_q <= OUT_DONE;
      rsp_rdata_q   <= '0;
      rsp_ec_q      <= '0;
    end else begin
      rsp_valid_q   <= req_valid_i;
      rsp_outcome_q <= req_valid_i ? outcome : OUT_DONE;
      rsp_rdata_q   <= done_rd ? {{PAD_W{1'b0}}, rd_val} : '0;
      rsp_ec_q      <= (req_valid_i && outcome == OUT_TRAP_HYP) ? EC_HYP_TRAP : '0;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_outcome_o = rsp_outcome_q;
  assign rsp_rdata_o   = rsp_rdata_q;
  assign rsp_ec_o      = rsp_ec_q;
  assign bp_s_o        = bp_s_q;
  assign bp_ns_o       = bp_ns_q;
endmodule

// File: rtl/grp1_bp_chk.sv
module grp1_bp_chk #(
  parameter int DATA_W = 32,
  parameter int BP_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_level_i,
  input logic              rsp_valid_o,
  input logic [2:0]        rsp_outcome_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [5:0]        rsp_ec_o,
  input logic [BP_W-1:0]   bp_s_o,
  input logic [BP_W-1:0]   bp_ns_o
);
  timeunit 1ns; timeprecision 1ps;

  // R1
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R1
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R1
  rdata_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rdata_o[DATA_W-1:BP_W] == '0);

  // R2
  user_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_level_i == 2'd0) |=> (rsp_outcome_o == 3'd1));

  // R9
  ec_hyp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_outcome_o == 3'd2) |-> (rsp_ec_o == 6'h03));

  // R9
  ec_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_outcome_o != 3'd2) |-> (rsp_ec_o == 6'h00));

  // R10
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsp_valid_o || rsp_outcome_o != 3'd0) |-> ($stable(bp_s_o) && $stable(bp_ns_o)));

  // R7
  bp_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_s_o != '0) && (bp_ns_o != '0));

  // R1
  outcome_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_outcome_o <= 3'd4);
endmodule

bind grp1_bp_ctrl grp1_bp_chk #(.DATA_W(DATA_W), .BP_W(BP_W)) i_grp1_bp_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_level_i  (req_level_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_outcome_o(rsp_outcome_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .rsp_ec_o     (rsp_ec_o),
  .bp_s_o       (bp_s_o),
  .bp_ns_o      (bp_ns_o)
);

// File: tb/test_grp1_bp_ctrl.sv
module test_grp1_bp_ctrl;
  timeunit 1ns; timeprecision 1ps;

  localparam int         DW   = 32;
  localparam int         BW   = 3;
  localparam logic [2:0] RSTV = 3'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_level = 2'd0;
  logic [DW-1:0] req_wdata = '0;
  logic el2_en = 0, undef_prio = 0, route_irq = 0, imo = 0, t12 = 0, tall1 = 0;
  logic sre_kern = 0, sre_hyp = 0, sre_mon = 0, ns = 0, cbpr = 0, sdd_undef = 0;
  logic [BW-1:0] bpr0 = '0;

  logic m_valid, n_valid;
  logic [2:0] m_out, n_out;
  logic [DW-1:0] m_rd, n_rd;
  logic [5:0] m_ec, n_ec;
  logic [BW-1:0] m_bs, m_bn, n_bs, n_bn;

  int n_vec = 0;
  int n_err = 0;
  logic [2:0] mdl_ns [2];
  logic [2:0] mdl_s  [2];

  always #10 clk = ~clk;

  grp1_bp_ctrl #(.DATA_W(DW), .BP_W(BW), .MIN_BPR0(2), .HAS_MONITOR(1'b1)) i_grp1_bp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_level_i(req_level), .req_wdata_i(req_wdata), .el2_en_i(el2_en),
    .undef_prio_i(undef_prio), .route_irq_i(route_irq), .imo_i(imo), .t12_i(t12),
    .tall1_i(tall1), .sre_kern_i(sre_kern), .sre_hyp_i(sre_hyp), .sre_mon_i(sre_mon),
    .ns_i(ns), .cbpr_i(cbpr), .sdd_undef_i(sdd_undef), .bpr0_i(bpr0),
    .rsp_valid_o(m_valid), .rsp_outcome_o(m_out), .rsp_rdata_o(m_rd), .rsp_ec_o(m_ec),
    .bp_s_o(m_bs), .bp_ns_o(m_bn));

  grp1_bp_ctrl #(.DATA_W(DW), .BP_W(BW), .MIN_BPR0(2), .HAS_MONITOR(1'b0)) i_grp1_bp_ctrl_nomon (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_level_i(req_level), .req_wdata_i(req_wdata), .el2_en_i(el2_en),
    .undef_prio_i(undef_prio), .route_irq_i(route_irq), .imo_i(imo), .t12_i(t12),
    .tall1_i(tall1), .sre_kern_i(sre_kern), .sre_hyp_i(sre_hyp), .sre_mon_i(sre_mon),
    .ns_i(ns), .cbpr_i(cbpr), .sdd_undef_i(sdd_undef), .bpr0_i(bpr0),
    .rsp_valid_o(n_valid), .rsp_outcome_o(n_out), .rsp_rdata_o(n_rd), .rsp_ec_o(n_ec),
    .bp_s_o(n_bs), .bp_ns_o(n_bn));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", tag, $time, act, exp);
    end
  endtask

  // outcome codes: 0 done, 1 undef, 2 hyp trap, 3 mon trap, 4 virtual
  function automatic logic [2:0] exp_outcome(bit mon, logic [1:0] lvl);
    bit irq = mon && route_irq;
    logic [2:0] trap_m = sdd_undef ? 3'd1 : 3'd3;
    case (lvl)
      2'd1: begin
        if (undef_prio && irq) return 3'd1;
        if (el2_en && t12)     return 3'd2;
        if (!sre_kern)         return 3'd1;
        if (el2_en && tall1)   return 3'd2;
        if (el2_en && imo)     return 3'd4;
        if (irq)               return trap_m;
        return 3'd0;
      end
      2'd2: begin
        if (undef_prio && irq) return 3'd1;
        if (!sre_hyp)          return 3'd1;
        if (irq)               return trap_m;
        return 3'd0;
      end
      2'd3: return (!mon || !sre_mon) ? 3'd1 : 3'd0;
      default: return 3'd1;
    endcase
  endfunction

  task automatic check_dut(int mon, logic v, logic [2:0] o, logic [31:0] rd,
                           logic [5:0] ec, logic [2:0] bs, logic [2:0] bn);
    logic [2:0] eo = exp_outcome(mon[0], req_level);
    bit al = (req_level == 2'd1 || req_level == 2'd2) && eo == 3'd0 && cbpr;
    bit ss = (req_level == 2'd3) && !ns;
    int sat = (int'(bpr0) + 1 > 7) ? 7 : int'(bpr0) + 1;
    logic [31:0] erd = '0;
    logic [2:0] wv;
    string lt = (req_level == 2'd0) ? "R2 outcome" : (req_level == 2'd1) ? "R3 outcome" :
                (req_level == 2'd2) ? "R4 outcome" : "R5 outcome";
    string st = "R10 state";
    if (!req_write && eo == 3'd0) erd = al ? 32'(sat) : 32'(ss ? mdl_s[mon] : mdl_ns[mon]);
    if (req_write && eo == 3'd0 && !al) begin
      wv = req_wdata[2:0];
      st = (wv == 3'd0) ? "R7 state" : "R8 state";
      if (wv == 3'd0) wv = RSTV;
      if (mon == 0 && wv < RSTV) wv = RSTV;
      if (ss) mdl_s[mon] = wv;
      else    mdl_ns[mon] = wv;
    end
    chk("R1 valid", 32'(v), 32'd1);
    chk(lt, 32'(o), 32'(eo));
    chk(al ? "R6 rdata" : "R1 rdata", rd, erd);
    chk("R9 ec", 32'(ec), (eo == 3'd2) ? 32'h3 : 32'h0);
    chk(st, 32'(bs), 32'(mdl_s[mon]));
    chk(st, 32'(bn), 32'(mdl_ns[mon]));
  endtask

  task automatic apply(logic [1:0] lvl, logic wr, logic [31:0] wd);
    req_valid = 1'b1; req_level = lvl; req_write = wr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    check_dut(1, m_valid, m_out, m_rd, m_ec, m_bs, m_bn);
    check_dut(0, n_valid, n_out, n_rd, n_ec, n_bs, n_bn);
  endtask

  task automatic base_ctrl();
    {el2_en, undef_prio, route_irq, imo, t12, tall1} = '0;
    {sre_kern, sre_hyp, sre_mon} = 3'b111;
    ns = 1'b1; cbpr = 1'b0; sdd_undef = 1'b0; bpr0 = 3'd2;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin mdl_ns[k] = RSTV; mdl_s[k] = RSTV; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid", 32'(m_valid), 0);
    chk("R11 bp_s", 32'(m_bs), 32'(RSTV));
    chk("R11 bp_ns", 32'(m_bn), 32'(RSTV));
    chk("R11 nomon bp_s", 32'(n_bs), 32'(RSTV));
    chk("R11 nomon bp_ns", 32'(n_bn), 32'(RSTV));

    base_ctrl();
    apply(2'd3, 1'b1, 32'h0);
    chk("R7 zero write", 32'(m_bn), 32'(RSTV));
    apply(2'd3, 1'b1, 32'h1);
    chk("R8 monitor keeps 1", 32'(m_bn), 1);
    chk("R5 nomon level3 undef", 32'(n_out), 1);
    apply(2'd1, 1'b1, 32'h1);
    chk("R8 clamp 1", 32'(n_bn), 32'(RSTV));
    apply(2'd1, 1'b1, 32'h2);
    chk("R8 clamp 2", 32'(n_bn), 32'(RSTV));
    chk("R3 mon ns write", 32'(m_bn), 2);
    apply(2'd1, 1'b1, 32'h6);
    chk("R8 above floor", 32'(n_bn), 6);
    ns = 1'b0;
    apply(2'd3, 1'b1, 32'hFFFF_FFFD);
    chk("R5 secure bank", 32'(m_bs), 5);
    apply(2'd3, 1'b0, 32'h0);
    chk("R1 hi bits zero", m_rd, 5);
    cbpr = 1'b1; bpr0 = 3'd7;
    apply(2'd1, 1'b0, 32'h0);
    chk("R6 saturate", m_rd, 7);
    apply(2'd2, 1'b1, 32'h4);
    chk("R6 write dropped", 32'(m_bn), 6);
    bpr0 = 3'd2;
    apply(2'd2, 1'b0, 32'h0);
    chk("R6 plus one", m_rd, 3);
    el2_en = 1'b1; imo = 1'b1;
    apply(2'd1, 1'b0, 32'h0);
    chk("R3 virtual", 32'(m_out), 4);
    route_irq = 1'b1;
    apply(2'd2, 1'b0, 32'h0);
    chk("R4 monitor trap", 32'(m_out), 3);
    chk("R4 nomon ignores irq", 32'(n_out), 0);
    t12 = 1'b1;
    apply(2'd1, 1'b0, 32'h0);
    chk("R3 hyp trap first", 32'(m_out), 2);
    chk("R9 ec value", 32'(m_ec), 3);
    apply(2'd0, 1'b0, 32'h0);
    chk("R2 user undef", 32'(m_out), 1);

    for (int i = 0; i < 32768; i++) begin
      {el2_en, undef_prio, route_irq, imo, t12, tall1,
       sre_kern, sre_hyp, sre_mon, ns, cbpr, sdd_undef} = i[14:3];
      bpr0 = 3'(i * 5 + (i >> 9));
      apply(i[1:0], i[2], (32'(i) * 32'h9E37_79B1) ^ (32'(i) << 7));
    end

    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 idle", 32'(m_valid), 0);
    chk("R1 idle nomon", 32'(n_valid), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule